// File: doc/BRIEF.md
# Banked data effective address generator

This block forms 24-bit data addresses for two address families: page-relative and bank-absolute. It keeps two base registers, a 16-bit page base and an 8-bit bank select, and each has its own write port. A page-relative request adds an 8-bit displacement to the page base and, if the mode asks for it, an index as well. The sum is 17 bits wide. A window that starts in bank 0 therefore carries into bank 1 when it crosses 0xFFFF, which happens for bases from 0xFF01 upward. A bank-absolute request places the bank select above a 16-bit operand and may add an index. In that case a carry runs on into the bank bits.

Results are registered and appear one cycle after the request, together with a valid strobe. A penalty flag goes out with each page-relative result. It reports one extra cycle of address arithmetic whenever the low byte of the page base is not zero. Fetching indirect pointers and making the memory access are the job of the surrounding pipeline.

Top module: `data_addr_gen`

## Requirements
- R1: After reset, valid_o, addr_o and extra_cycle_o are 0, and both base registers hold 0.
- R2: A base register write takes effect on the next cycle. A request made in the same cycle as a write uses the old value.
- R3: Mode 2'b00 (page): addr_o = zero-extended 17-bit (page_base + offset_i). Bits 23:17 are always 0, and bit 16 is set when the sum carries past 0xFFFF.
- R4: Mode 2'b01 (page indexed): addr_o = zero-extended (page_base + offset_i + index) mod 2^17.
- R5: Mode 2'b10 (absolute): addr_o = {bank, operand_i}.
- R6: Mode 2'b11 (absolute indexed): addr_o = ({bank, operand_i} + index) mod 2^24. A carry increments the bank bits.
- R7: When idx_wide_i = 0, the index is index_i[7:0] and index_i[15:8] has no effect. When idx_wide_i = 1, all 16 bits are used.
- R8: extra_cycle_o = 1 for page modes (2'b00, 2'b01) when page_base[7:0] != 0. Otherwise it is 0, and it is always 0 for absolute modes.
- R9: valid_o is high exactly in the cycle after a cycle with req_valid_i high. addr_o and extra_cycle_o hold their values when there is no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dpr_we_i | input | 1 | Page base write enable |
| dpr_wdata_i | input | 16 | Page base write data |
| dbr_we_i | input | 1 | Bank select write enable |
| dbr_wdata_i | input | 8 | Bank select write data |
| req_valid_i | input | 1 | Address request |
| mode_i | input | 2 | 00 page, 01 page indexed, 10 absolute, 11 absolute indexed |
| offset_i | input | 8 | Page displacement |
| operand_i | input | 16 | Absolute operand |
| index_i | input | 16 | Index value |
| idx_wide_i | input | 1 | 1: 16-bit index, 0: 8-bit index |
| valid_o | output | 1 | Result valid |
| addr_o | output | 24 | Effective address |
| extra_cycle_o | output | 1 | Page base low byte nonzero penalty |

## Verification
Every result is due exactly one clock after its request. A base register write becomes visible to requests made one cycle later. The driver applies stimulus at the falling edge and pushes its expected address and penalty flag into a queue. That expectation is computed from a bench copy of the two base registers, read before the same cycle's writes are applied. The monitor samples on the next falling edge and pops one item for each cycle in which valid_o is high. A strobe that comes early or is missing leaves the queue out of step, and this shows up as a mismatch or as leftover entries. Idle-cycle holds and same-cycle write collisions are checked at those same sample points.

// File: rtl/dag_pkg.sv
package dag_pkg;
  typedef enum logic [1:0] {
    MODE_PAGE   = 2'b00,
    MODE_PAGE_X = 2'b01,
    MODE_ABS    = 2'b10,
    MODE_ABS_X  = 2'b11
  } dag_mode_e;

  function automatic logic mode_is_abs(input logic [1:0] m);
    return m[1];
  endfunction

  function automatic logic mode_is_indexed(input logic [1:0] m);
    return m[0];
  endfunction
endpackage

// File: rtl/dag_bank_regs.sv
module dag_bank_regs #(
  parameter int BASE_W = 16,
  parameter int BANK_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              base_we_i,
  input  logic [BASE_W-1:0] base_wdata_i,
  input  logic              bank_we_i,
  input  logic [BANK_W-1:0] bank_wdata_i,
  output logic [BASE_W-1:0] base_o,
  output logic [BANK_W-1:0] bank_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o <= '0;
      bank_o <= '0;
    end else begin
      if (base_we_i) base_o <= base_wdata_i;
      if (bank_we_i) bank_o <= bank_wdata_i;
    end
  end

  // R2
  base_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    base_we_i |=> base_o == $past(base_wdata_i));
  // R2
  bank_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bank_we_i |=> bank_o == $past(bank_wdata_i));
endmodule

// File: rtl/dag_page_calc.sv
module dag_page_calc #(
  parameter int BASE_W = 16,
  parameter int OFS_W  = 8,
  parameter int IDX_W  = 16,
  parameter int ADDR_W = 24
) (
  input  logic [BASE_W-1:0] base_i,
  input  logic [OFS_W-1:0]  offset_i,
  input  logic [IDX_W-1:0]  index_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              penalty_o
);
  localparam int SUM_W = BASE_W + 1;

  logic [SUM_W-1:0] sum;

  always_comb begin
    sum = {1'b0, base_i} + SUM_W'(offset_i) + SUM_W'(index_i);
    addr_o = ADDR_W'(sum);
    // unaligned page base costs one more adder pass
    penalty_o = |base_i[OFS_W-1:0];
  end
endmodule

// File: rtl/dag_abs_calc.sv
module dag_abs_calc #(
  parameter int BANK_W = 8,
  parameter int OPND_W = 16,
  parameter int IDX_W  = 16,
  parameter int ADDR_W = 24
) (
  input  logic [BANK_W-1:0] bank_i,
  input  logic [OPND_W-1:0] operand_i,
  input  logic [IDX_W-1:0]  index_i,
  output logic [ADDR_W-1:0] addr_o
);
  always_comb addr_o = {bank_i, operand_i} + ADDR_W'(index_i);
endmodule

// File: rtl/data_addr_gen.sv
module data_addr_gen #(
  parameter int BASE_W = 16,
  parameter int BANK_W = 8,
  parameter int OFS_W  = 8,
  parameter int IDX_W  = 16,
  localparam int ADDR_W = BANK_W + BASE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dpr_we_i,
  input  logic [BASE_W-1:0] dpr_wdata_i,
  input  logic              dbr_we_i,
  input  logic [BANK_W-1:0] dbr_wdata_i,
  input  logic              req_valid_i,
  input  logic [1:0]        mode_i,
  input  logic [OFS_W-1:0]  offset_i,
  input  logic [BASE_W-1:0] operand_i,
  input  logic [IDX_W-1:0]  index_i,
  input  logic              idx_wide_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              extra_cycle_o
);
  import dag_pkg::*;

  localparam int NARROW_W = OFS_W;

  logic [BASE_W-1:0] base_q;
  logic [BANK_W-1:0] bank_q;
  logic [IDX_W-1:0]  idx_eff;
  logic [ADDR_W-1:0] page_addr, abs_addr;
  logic              page_pen;

  dag_bank_regs #(.BASE_W(BASE_W), .BANK_W(BANK_W)) u_regs (
    .clk_i, .rst_ni,
    .base_we_i(dpr_we_i), .base_wdata_i(dpr_wdata_i),
    .bank_we_i(dbr_we_i), .bank_wdata_i(dbr_wdata_i),
    .base_o(base_q), .bank_o(bank_q)
  );

  generate
    if (IDX_W > NARROW_W) begin : g_idx_sel
      always_comb begin
        if (!mode_is_indexed(mode_i)) idx_eff = '0;
        else if (idx_wide_i)          idx_eff = index_i;
        else idx_eff = {{(IDX_W-NARROW_W){1'b0}}, index_i[NARROW_W-1:0]};
      end
    end else begin : g_idx_pass
      always_comb idx_eff = mode_is_indexed(mode_i) ? index_i : '0;
    end
  endgenerate

  dag_page_calc #(.BASE_W(BASE_W), .OFS_W(OFS_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_page (
    .base_i(base_q), .offset_i(offset_i), .index_i(idx_eff),
    .addr_o(page_addr), .penalty_o(page_pen)
  );

  dag_abs_calc #(.BANK_W(BANK_W), .OPND_W(BASE_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_abs (
    .bank_i(bank_q), .operand_i(operand_i), .index_i(idx_eff), .addr_o(abs_addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o       <= 1'b0;
      addr_o        <= '0;
      extra_cycle_o <= 1'b0;
    end else begin
      valid_o <= req_valid_i;
      if (req_valid_i) begin
        addr_o        <= mode_is_abs(mode_i) ? abs_addr : page_addr;
        extra_cycle_o <= mode_is_abs(mode_i) ? 1'b0 : page_pen;
      end
    end
  end

  // R9
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> valid_o);
  // R9
  valid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !valid_o && $stable(addr_o) && $stable(extra_cycle_o));
  // R3
  page_high_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !mode_i[1]) |=> addr_o[ADDR_W-1:BASE_W+1] == '0);
  // R5
  abs_bank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && mode_i == MODE_ABS) |=> addr_o[ADDR_W-1:BASE_W] == $past(bank_q));
  // R8
  abs_no_penalty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && mode_i[1]) |=> !extra_cycle_o);
  // R8
  page_penalty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !mode_i[1]) |=> extra_cycle_o == ($past(base_q[OFS_W-1:0]) != '0));
endmodule

// File: tb/data_addr_gen_bench.sv
`timescale 1ns/1ps
module data_addr_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dpr_we = 1'b0, dbr_we = 1'b0, req = 1'b0, wide = 1'b0;
  logic [15:0] dpr_wd = '0, operand = '0, index = '0;
  logic [7:0]  dbr_wd = '0, offset = '0;
  logic [1:0]  mode = '0;
  logic        valid;
  logic [23:0] addr;
  logic        extra;

  always #5 clk = ~clk;

  data_addr_gen u_data_addr_gen (
    .clk_i(clk), .rst_ni(rst_n),
    .dpr_we_i(dpr_we), .dpr_wdata_i(dpr_wd),
    .dbr_we_i(dbr_we), .dbr_wdata_i(dbr_wd),
    .req_valid_i(req), .mode_i(mode), .offset_i(offset),
    .operand_i(operand), .index_i(index), .idx_wide_i(wide),
    .valid_o(valid), .addr_o(addr), .extra_cycle_o(extra)
  );

  typedef struct { logic [23:0] a; logic e; string tag; } exp_t;
  exp_t sb[$];
  int compared = 0, mismatched = 0;
  logic [15:0] m_base = '0;
  logic [7:0]  m_bank = '0;
  bit mon_on = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one cycle of stimulus at the falling edge; expectation uses pre-write model
  task automatic step(input bit r, input logic [1:0] md, input logic [7:0] ofs,
                      input logic [15:0] opd, input logic [15:0] ix, input bit wd,
                      input bit bw, input logic [15:0] bv, input bit kw, input logic [7:0] kv,
                      input string tag);
    exp_t it;
    logic [15:0] ie;
    logic [16:0] ps;
    @(negedge clk);
    req = r; mode = md; offset = ofs; operand = opd; index = ix; wide = wd;
    dpr_we = bw; dpr_wd = bv; dbr_we = kw; dbr_wd = kv;
    if (r) begin
      ie = !md[0] ? 16'h0 : (wd ? ix : {8'h00, ix[7:0]});
      if (md[1]) begin
        it.a = {m_bank, opd} + {8'h00, ie};
        it.e = 1'b0;
      end else begin
        ps = {1'b0, m_base} + {9'h0, ofs} + {1'b0, ie};
        it.a = {7'h0, ps};
        it.e = (m_base[7:0] != 8'h00);
      end
      it.tag = tag;
      sb.push_back(it);
    end
    if (bw) m_base = bv;
    if (kw) m_bank = kv;
  endtask

  task automatic idle();
    step(0, 2'b00, 8'h0, 16'h0, 16'h0, 0, 0, 16'h0, 0, 8'h0, "idle");
  endtask

  always @(negedge clk) begin
    if (mon_on && valid) begin
      if (sb.size() == 0) begin
        check("R9 unexpected valid", {31'h0, valid}, 32'h0);
      end else begin
        exp_t it;
        it = sb.pop_front();
        check({it.tag, " addr"}, {8'h0, addr}, {8'h0, it.a});
        check({it.tag, " extra"}, {31'h0, extra}, {31'h0, it.e});
      end
    end
  end

  initial begin : watchdog
    #200000;
    mismatched++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [23:0] held;
    repeat (3) @(negedge clk);
    // R1 reset values
    check("R1 valid", {31'h0, valid}, 32'h0);
    check("R1 addr", {8'h0, addr}, 32'h0);
    check("R1 extra", {31'h0, extra}, 32'h0);
    rst_n = 1'b1;
    mon_on = 1'b1;
    // R1 registers zero after reset
    step(1, 2'b00, 8'h00, 16'h0, 16'h0, 0, 0, 16'h0, 0, 8'h0, "R1 page");
    step(1, 2'b10, 8'h00, 16'h1234, 16'h0, 0, 0, 16'h0, 0, 8'h0, "R1 abs");
    idle();
    // R3 page base aligned and spill into bank 1
    step(0, 2'b00, 8'h0, 16'h0, 16'h0, 0, 1, 16'h1200, 0, 8'h0, "wr");
    step(1, 2'b00, 8'h34, 16'h0, 16'h0, 0, 0, 16'h0, 0, 8'h0, "R3 aligned");
    step(0, 2'b00, 8'h0, 16'h0, 16'h0, 0, 1, 16'hFF00, 0, 8'h0, "wr");
    step(1, 2'b00, 8'hFF, 16'h0, 16'h0, 0, 0, 16'h0, 0, 8'h0, "R3 edge no spill");
    step(0, 2'b00, 8'h0, 16'h0, 16'h0, 0, 1, 16'hFF01, 0, 8'h0, "wr");
    step(1, 2'b00, 8'hFF, 16'h0, 16'h0, 0, 0, 16'h0, 0, 8'h0, "R3 R8 spill bank1");
    // R4 page indexed
    step(0, 2'b00, 8'h0, 16'h0, 16'h0, 0, 1, 16'h0100, 0, 8'h0, "wr");
    step(1, 2'b01, 8'h10, 16'h0, 16'h0020, 1, 0, 16'h0, 0, 8'h0, "R4 indexed");
    step(0, 2'b00, 8'h0, 16'h0, 16'h0, 0, 1, 16'hFFF0, 0, 8'h0, "wr");
    step(1, 2'b01, 8'h08, 16'h0, 16'h0010, 1, 0, 16'h0, 0, 8'h0, "R4 R8 indexed spill");
    step(1, 2'b01, 8'hFF, 16'h0, 16'hFFFF, 1, 0, 16'h0, 0, 8'h0, "R4 wrap 17b");
    // R5 / R6 absolute
    step(0, 2'b00, 8'h0, 16'h0, 16'h0, 0, 0, 16'h0, 1, 8'h7E, "wr");
    step(1, 2'b10, 8'h00, 16'hABCD, 16'hFFFF, 1, 0, 16'h0, 0, 8'h0, "R5 R8 absolute");
    step(1, 2'b11, 8'h00, 16'hFFF0, 16'h0020, 1, 0, 16'h0, 0, 8'h0, "R6 bank carry");
    step(0, 2'b00, 8'h0, 16'h0, 16'h0, 0, 0, 16'h0, 1, 8'hFF, "wr");
    step(1, 2'b11, 8'h00, 16'hFFFF, 16'h0001, 1, 0, 16'h0, 0, 8'h0, "R6 wrap 24b");
    // R7 narrow index ignores upper byte
    step(1, 2'b11, 8'h00, 16'h0100, 16'hAB05, 0, 0, 16'h0, 0, 8'h0, "R7 abs narrow");
    step(1, 2'b01, 8'h01, 16'h0, 16'hFF02, 0, 0, 16'h0, 0, 8'h0, "R7 page narrow");
    // R2 same-cycle write uses old value, next cycle new
    step(1, 2'b00, 8'h01, 16'h0, 16'h0, 0, 1, 16'h3400, 0, 8'h0, "R2 old base");
    step(1, 2'b00, 8'h01, 16'h0, 16'h0, 0, 0, 16'h0, 0, 8'h0, "R2 new base");
    step(1, 2'b10, 8'h00, 16'h5555, 16'h0, 0, 0, 16'h0, 1, 8'h12, "R2 old bank");
    step(1, 2'b10, 8'h00, 16'h5555, 16'h0, 0, 0, 16'h0, 0, 8'h0, "R2 new bank");
    idle();
    // R9 outputs hold across idle cycles
    @(negedge clk);
    held = addr;
    check("R9 idle valid", {31'h0, valid}, 32'h0);
    check("R9 hold addr", {8'h0, held}, {8'h0, 24'h125555});
    idle();
    @(negedge clk);
    check("R9 hold addr later", {8'h0, addr}, {8'h0, held});
    check("R9 queue drained", sb.size(), 32'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule